// File: doc/BRIEF.md
# Packed-Integer SIMD Execution Unit

This unit is a 64-bit execution stage for packed integer data. Each operand is cut into lanes of eight, sixteen or thirty-two bits, and one operation runs on every lane at the same time. No carry, borrow or shifted bit passes from one lane into the next. It covers the lane operations that a scalar ALU lacks: add and subtract with per-lane saturation, compare masks, 16-bit lane multiplies, pairwise multiply-accumulate, in-lane shifts, bitwise logic, narrowing pack and interleaving unpack.

An operation is issued by raising `in_valid` together with both sources, an opcode, a lane size, a saturation enable and a signedness flag. One clock edge later the result shows on `result` and `out_valid` is high. A new operation can be issued on every cycle. The block does not stall.

Top module: `simd_alu`

## Requirements
- R1: An input accepted on one clock edge (`in_valid` high) gives `out_valid` high and its result after that same edge, so there is exactly one register stage. With `in_valid` low, `out_valid` drops and `result` keeps its old value. A synchronous active-low reset clears both `out_valid` and `result`.
- R2: `elem_size` sets the lane width: 0 means 8 bits, 1 means 16 bits, 2 and 3 both mean 32 bits. Lane n takes bits starting at n times the width. With `sat_en` low, ADD (opcode 0) and SUB (opcode 1, src_a minus src_b) wrap modulo the lane width, and a carry never leaves its lane.
- R3: With `sat_en` high, ADD and SUB clamp each lane. When `is_signed` is 1 the range is -2^(w-1) to 2^(w-1)-1. When `is_signed` is 0 the range is 0 to 2^w-1.
- R4: CMPEQ (opcode 2) and CMPGT (opcode 3, src_a greater than src_b) fill a lane with all ones when the condition holds and with zeros otherwise. CMPGT compares as signed numbers when `is_signed` is 1 and as unsigned numbers when it is 0.
- R5: MULLO (opcode 4) and MULHI (opcode 5) always use four 16-bit lanes, whatever `elem_size` is. They return bits 15:0 or bits 31:16 of each 32-bit product. The operands count as signed when `is_signed` is 1 and as unsigned when it is 0.
- R6: MADD (opcode 6) forms the four 16-bit products. Word 0 of the result is product 0 plus product 1, and word 1 is product 2 plus product 3. Each sum wraps to 32 bits, and signedness follows `is_signed`.
- R7: SLL (7), SRL (8) and SRA (9) shift every lane of src_a by the count in src_b[7:0]. The higher bits of src_b are ignored. SRA fills a lane from that lane's own sign bit.
- R8: If the shift count is equal to or larger than the lane width, SLL and SRL give zero and SRA gives a lane filled with its sign bit.
- R9: AND (10), ANDN (11, src_a AND NOT src_b), OR (12) and XOR (13) work bit by bit across all 64 bits.
- R10: PACK (14) narrows each lane of width w (`elem_size` 1 or 2) to w/2 with saturation. When `is_signed` is 1 it clamps signed. When `is_signed` is 0 it reads the source as signed and clamps to 0 to 2^(w/2)-1. The narrowed src_a lanes fill the low 32 bits and the narrowed src_b lanes fill the high 32 bits, with lane order kept. PACK with byte size returns zero.
- R11: UNPKLO (15) interleaves the lanes of the low halves: result lane 2i is src_a lane i and lane 2i+1 is src_b lane i. UNPKHI (16) does the same with the lanes of the high halves.
- R12: Opcodes 17 to 31 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| opcode | input | 5 | Operation code |
| elem_size | input | 2 | Lane width select |
| sat_en | input | 1 | Saturating add/subtract |
| is_signed | input | 1 | Signed interpretation |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source, also the shift count |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
One addition vector is run at all three lane sizes. It carries out of a byte and out of a halfword, so each size produces a different word and any carry leaking across a lane boundary shows up. The saturating vectors put a lane that overflows next to a lane that does not. Signed and unsigned runs with the same operands separate the clamping and the comparison under the two signedness settings. Shift patterns use counts inside the lane width, equal to it and beyond it, plus a count with stray high bits. The multiply and permute vectors use distinct byte values, so that a swapped lane, a wrong half or a wrong sign extension changes the output.

// File: rtl/simd_alu_pkg.sv
// Shared opcode encoding and lane-size constants for the packed-integer unit.
package simd_alu_pkg;
    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_CMPEQ  = 5'd2,
        OP_CMPGT  = 5'd3,
        OP_MULLO  = 5'd4,
        OP_MULHI  = 5'd5,
        OP_MADD   = 5'd6,
        OP_SLL    = 5'd7,
        OP_SRL    = 5'd8,
        OP_SRA    = 5'd9,
        OP_AND    = 5'd10,
        OP_ANDN   = 5'd11,
        OP_OR     = 5'd12,
        OP_XOR    = 5'd13,
        OP_PACK   = 5'd14,
        OP_UNPKLO = 5'd15,
        OP_UNPKHI = 5'd16
    } simd_op_e;

    localparam int unsigned NUM_SIZES = 3;   // 8, 16, 32-bit lanes
    localparam int unsigned BASE_LW   = 8;   // smallest lane width
endpackage

// File: rtl/simd_lane_unit.sv
// Lane-parallel add/subtract with optional saturation, compare masks and
// in-lane shifts for one fixed lane width LW.
// Assumes DW is a multiple of LW and that LW is no wider than 255.
module simd_lane_unit #(
    parameter int unsigned DW = 64,
    parameter int unsigned LW = 8,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic          do_sub,
    input  logic          sat_en,
    input  logic          is_signed,
    input  logic [CW-1:0] sh_cnt,
    output logic [DW-1:0] arith,
    output logic [DW-1:0] cmp_eq,
    output logic [DW-1:0] cmp_gt,
    output logic [DW-1:0] sh_ll,
    output logic [DW-1:0] sh_rl,
    output logic [DW-1:0] sh_ra
);
    localparam int unsigned NL = DW / LW;
    localparam logic [CW-1:0] LW_C = CW'(LW);

    logic sh_big;
    assign sh_big = (sh_cnt >= LW_C);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] la, lb, res;
        logic [LW+1:0] wa, wb, ws;
        logic          eq_b, gt_b;

        assign la = src_a[i*LW +: LW];
        assign lb = src_b[i*LW +: LW];
        assign wa = {{2{is_signed & la[LW-1]}}, la};
        assign wb = {{2{is_signed & lb[LW-1]}}, lb};
        assign ws = do_sub ? (wa - wb) : (wa + wb);

        // Wrap or clamp the widened lane sum to the lane range.
        always_comb begin
            res = ws[LW-1:0];
            if (sat_en) begin
                if (is_signed) begin
                    if (ws[LW] != ws[LW-1])
                        res = ws[LW+1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                end else begin
                    if (ws[LW+1])
                        res = '0;
                    else if (ws[LW])
                        res = '1;
                end
            end
        end

        assign eq_b = (la == lb);
        assign gt_b = is_signed ? ($signed(la) > $signed(lb)) : (la > lb);

        assign arith [i*LW +: LW] = res;
        assign cmp_eq[i*LW +: LW] = {LW{eq_b}};
        assign cmp_gt[i*LW +: LW] = {LW{gt_b}};
        assign sh_ll [i*LW +: LW] = sh_big ? '0 : (la << sh_cnt);
        assign sh_rl [i*LW +: LW] = sh_big ? '0 : (la >> sh_cnt);
        assign sh_ra [i*LW +: LW] = sh_big ? {LW{la[LW-1]}} : LW'($signed(la) >>> sh_cnt);

        // R3: an unsigned saturating add never falls below its first operand
        p_satadd_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sat_en && !is_signed && !do_sub) |-> (arith[i*LW +: LW] >= la));
        // R4: equal and greater masks never both set in one lane
        p_cmp_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(cmp_eq[i*LW] && cmp_gt[i*LW]));
        // R8: arithmetic right shift keeps the lane's own sign in its top bit
        p_sra_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
            sh_ra[i*LW+LW-1] == la[LW-1]);
    end
endmodule

// File: rtl/simd_mul_unit.sv
// Four-lane 16-bit multiplier producing low halves, high halves and
// pairwise-summed 32-bit products. Assumes DW is a multiple of 32.
module simd_mul_unit #(
    parameter int unsigned DW = 64,
    parameter int unsigned MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic          is_signed,
    output logic [DW-1:0] mul_lo,
    output logic [DW-1:0] mul_hi,
    output logic [DW-1:0] madd
);
    localparam int unsigned NL = DW / MW;
    localparam int unsigned PW = 2 * MW;

    logic signed [PW-1:0] prod [NL];

    for (genvar i = 0; i < NL; i++) begin : g_mul
        logic signed [PW-1:0] xa, xb;
        assign xa = {{MW{is_signed & src_a[i*MW+MW-1]}}, src_a[i*MW +: MW]};
        assign xb = {{MW{is_signed & src_b[i*MW+MW-1]}}, src_b[i*MW +: MW]};
        assign prod[i] = xa * xb;
        assign mul_lo[i*MW +: MW] = prod[i][MW-1:0];
        assign mul_hi[i*MW +: MW] = prod[i][PW-1:MW];
    end

    for (genvar p = 0; p < NL/2; p++) begin : g_madd
        assign madd[p*PW +: PW] = prod[2*p] + prod[2*p+1];
    end

    // R6: a zero multiplier source gives a zero multiply-add result
    p_madd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b == '0) |-> (madd == '0));
endmodule

// File: rtl/simd_permute_unit.sv
// Saturating pack (lane halving) and low/high interleaving unpack for
// every lane size; the lane size select picks the variant.
module simd_permute_unit #(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic          is_signed,
    input  logic [1:0]    size_idx,
    output logic [DW-1:0] pack_res,
    output logic [DW-1:0] unpk_lo,
    output logic [DW-1:0] unpk_hi
);
    import simd_alu_pkg::*;

    logic [DW-1:0] pk_s [NUM_SIZES];
    logic [DW-1:0] lo_s [NUM_SIZES];
    logic [DW-1:0] hi_s [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int unsigned W = BASE_LW << s;
        localparam int unsigned N = DW / W;
        localparam int unsigned H = W / 2;

        // Interleave lanes of the low and high source halves.
        always_comb begin
            lo_s[s] = '0;
            hi_s[s] = '0;
            for (int i = 0; i < N/2; i++) begin
                lo_s[s][2*i*W +: W]     = src_a[i*W +: W];
                lo_s[s][(2*i+1)*W +: W] = src_b[i*W +: W];
                hi_s[s][2*i*W +: W]     = src_a[(i+N/2)*W +: W];
                hi_s[s][(2*i+1)*W +: W] = src_b[(i+N/2)*W +: W];
            end
        end

        if (s == 0) begin : g_nopack
            assign pk_s[s] = '0;
        end else begin : g_pack
            function automatic logic [H-1:0] narrow(input logic [W-1:0] x, input logic sgn);
                logic [W-H:0] top;
                top = x[W-1:H-1];
                if (sgn) begin
                    if (!(top == '0 || top == '1))
                        return x[W-1] ? {1'b1, {(H-1){1'b0}}} : {1'b0, {(H-1){1'b1}}};
                    return x[H-1:0];
                end
                if (x[W-1])
                    return '0;
                if (x[W-1:H] != '0)
                    return '1;
                return x[H-1:0];
            endfunction

            // Narrow every lane of both sources and concatenate.
            always_comb begin
                pk_s[s] = '0;
                for (int i = 0; i < N; i++) begin
                    pk_s[s][i*H +: H]        = narrow(src_a[i*W +: W], is_signed);
                    pk_s[s][DW/2 + i*H +: H] = narrow(src_b[i*W +: W], is_signed);
                end
            end
        end
    end

    assign pack_res = pk_s[size_idx];
    assign unpk_lo  = lo_s[size_idx];
    assign unpk_hi  = hi_s[size_idx];
endmodule

// File: rtl/simd_alu.sv
// Top of the packed-integer execution unit: lane units for each width,
// the 16-bit multiplier, the permute unit, an opcode result mux and one
// output register stage. Assumes DATA_W is 64 and issue never stalls.
module simd_alu #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        opcode,
    input  logic [1:0]        elem_size,
    input  logic              sat_en,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import simd_alu_pkg::*;

    simd_op_e    op;
    logic [1:0]  size_idx;
    logic        do_sub;
    logic [DATA_W-1:0] next_res;

    logic [DATA_W-1:0] arith_s [NUM_SIZES];
    logic [DATA_W-1:0] eq_s    [NUM_SIZES];
    logic [DATA_W-1:0] gt_s    [NUM_SIZES];
    logic [DATA_W-1:0] sll_s   [NUM_SIZES];
    logic [DATA_W-1:0] srl_s   [NUM_SIZES];
    logic [DATA_W-1:0] sra_s   [NUM_SIZES];
    logic [DATA_W-1:0] mul_lo, mul_hi, madd;
    logic [DATA_W-1:0] pack_res, unpk_lo, unpk_hi;

    assign op       = simd_op_e'(opcode);
    assign size_idx = (elem_size == 2'd3) ? 2'd2 : elem_size;
    assign do_sub   = (op == OP_SUB);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_lanes
        simd_lane_unit #(.DW(DATA_W), .LW(BASE_LW << s), .CW(CNT_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_a     (src_a),
            .src_b     (src_b),
            .do_sub    (do_sub),
            .sat_en    (sat_en),
            .is_signed (is_signed),
            .sh_cnt    (src_b[CNT_W-1:0]),
            .arith     (arith_s[s]),
            .cmp_eq    (eq_s[s]),
            .cmp_gt    (gt_s[s]),
            .sh_ll     (sll_s[s]),
            .sh_rl     (srl_s[s]),
            .sh_ra     (sra_s[s])
        );
    end

    simd_mul_unit #(.DW(DATA_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .is_signed (is_signed),
        .mul_lo    (mul_lo),
        .mul_hi    (mul_hi),
        .madd      (madd)
    );

    simd_permute_unit #(.DW(DATA_W)) u_perm (
        .src_a     (src_a),
        .src_b     (src_b),
        .is_signed (is_signed),
        .size_idx  (size_idx),
        .pack_res  (pack_res),
        .unpk_lo   (unpk_lo),
        .unpk_hi   (unpk_hi)
    );

    // Pick the result of the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: next_res = arith_s[size_idx];
            OP_CMPEQ:       next_res = eq_s[size_idx];
            OP_CMPGT:       next_res = gt_s[size_idx];
            OP_MULLO:       next_res = mul_lo;
            OP_MULHI:       next_res = mul_hi;
            OP_MADD:        next_res = madd;
            OP_SLL:         next_res = sll_s[size_idx];
            OP_SRL:         next_res = srl_s[size_idx];
            OP_SRA:         next_res = sra_s[size_idx];
            OP_AND:         next_res = src_a & src_b;
            OP_ANDN:        next_res = src_a & ~src_b;
            OP_OR:          next_res = src_a | src_b;
            OP_XOR:         next_res = src_a ^ src_b;
            OP_PACK:        next_res = pack_res;
            OP_UNPKLO:      next_res = unpk_lo;
            OP_UNPKHI:      next_res = unpk_hi;
            default:        next_res = '0;
        endcase
    end

    // Output register: capture on issue, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end

    // R1: an issued operation is valid on the next cycle
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1: no issue means no valid output next cycle
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1: the result holds while nothing is issued
    p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
endmodule

// File: tb/simd_alu_bench.sv
`timescale 1ns/1ps
module simd_alu_bench;
    localparam logic [4:0] ADD = 5'd0, SUB = 5'd1, CEQ = 5'd2, CGT = 5'd3,
                           MLO = 5'd4, MHI = 5'd5, MAD = 5'd6, SLL = 5'd7,
                           SRL = 5'd8, SRA = 5'd9, AND = 5'd10, ANDN = 5'd11,
                           OR = 5'd12, XOR = 5'd13, PCK = 5'd14, ULO = 5'd15,
                           UHI = 5'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [1:0]  elem_size = '0;
    logic        sat_en = 1'b0;
    logic        is_signed = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .elem_size(elem_size), .sat_en(sat_en), .is_signed(is_signed),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issue one operation and queue its expected result.
    task automatic send(input logic [4:0] op, input logic [1:0] sz, input logic sat,
                        input logic sgn, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; elem_size = sz; sat_en = sat;
        is_signed = sgn; src_a = a; src_b = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each valid result with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected valid", result, 64'hx);
            end else begin
                check(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;

        // R2 wrap add, three sizes on one pattern, plus word carry cut
        send(ADD, 2'd0, 0, 0, 64'h0000_0000_0000_FF80, 64'h80, 64'h0000_0000_0000_FF00, "R2 add byte");
        send(ADD, 2'd1, 0, 0, 64'h0000_0000_0000_FF80, 64'h80, 64'h0, "R2 add half");
        send(ADD, 2'd2, 0, 0, 64'h0000_0000_0000_FF80, 64'h80, 64'h0000_0000_0001_0000, "R2 add word");
        send(ADD, 2'd3, 0, 0, 64'h0000_0000_0000_FF80, 64'h80, 64'h0000_0000_0001_0000, "R2 add size3");
        send(ADD, 2'd2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_0000_0000, "R2 add word cut");
        send(SUB, 2'd0, 0, 0, 64'h0, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, "R2 sub byte");
        // R3 saturation
        send(ADD, 2'd0, 1, 1, 64'h7F80_0000_0000_0005, 64'h0180_0000_0000_0003, 64'h7F80_0000_0000_0008, "R3 sadd signed byte");
        send(ADD, 2'd1, 1, 0, 64'hFFF0_0001_0000_0000, 64'h0020_0002_0000_0000, 64'hFFFF_0003_0000_0000, "R3 sadd unsigned half");
        send(SUB, 2'd0, 1, 0, 64'h1005, 64'h0510, 64'h0B00, "R3 ssub unsigned byte");
        send(SUB, 2'd2, 1, 1, 64'h8000_0000_0000_0005, 64'h0000_0001_0000_0007, 64'h8000_0000_FFFF_FFFE, "R3 ssub signed word");
        // R4 compares
        send(CEQ, 2'd0, 0, 0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, "R4 cmpeq byte");
        send(CGT, 2'd1, 0, 1, 64'h8000_0001_7FFF_0005, 64'h0001_8000_0000_0005, 64'h0000_FFFF_FFFF_0000, "R4 cmpgt signed");
        send(CGT, 2'd1, 0, 0, 64'h8000_0001_7FFF_0005, 64'h0001_8000_0000_0005, 64'hFFFF_0000_FFFF_0000, "R4 cmpgt unsigned");
        // R5 multiply, elem_size ignored
        send(MLO, 2'd0, 0, 1, 64'h0002_FFFF_0100_7FFF, 64'h0003_FFFF_0100_0002, 64'h0006_0001_0000_FFFE, "R5 mullo");
        send(MHI, 2'd2, 0, 1, 64'h0002_FFFF_0100_7FFF, 64'h0003_FFFF_0100_0002, 64'h0000_0000_0001_0000, "R5 mulhi signed");
        send(MHI, 2'd1, 0, 0, 64'h0002_FFFF_0100_7FFF, 64'h0003_FFFF_0100_0002, 64'h0000_FFFE_0001_0000, "R5 mulhi unsigned");
        // R6 multiply-add
        send(MAD, 2'd1, 0, 1, 64'h0002_0003_FFFF_0001, 64'h0005_0006_0005_0002, 64'h0000_001C_FFFF_FFFD, "R6 madd signed");
        send(MAD, 2'd1, 0, 0, 64'h0002_0003_FFFF_0001, 64'h0005_0006_0005_0002, 64'h0000_001C_0004_FFFD, "R6 madd unsigned");
        // R7 shifts
        send(SLL, 2'd0, 0, 0, 64'h8040_01FF_0000_0081, 64'h1, 64'h0080_02FE_0000_0002, "R7 sll byte");
        send(SRL, 2'd1, 0, 0, 64'h8001_00F0_1234_FFFF, 64'h4, 64'h0800_000F_0123_0FFF, "R7 srl half");
        send(SRL, 2'd1, 0, 0, 64'h8001_00F0_1234_FFFF, 64'h104, 64'h0800_000F_0123_0FFF, "R7 count high bits ignored");
        send(SRA, 2'd1, 0, 0, 64'h8001_00F0_1234_FFFF, 64'h4, 64'hF800_000F_0123_FFFF, "R7 sra half");
        // R8 oversize counts
        send(SRA, 2'd2, 0, 0, 64'h8000_0000_7FFF_FFFF, 64'h28, 64'hFFFF_FFFF_0000_0000, "R8 sra word big");
        send(SLL, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8, 64'h0, "R8 sll byte eq width");
        send(SRL, 2'd2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h20, 64'h0, "R8 srl word eq width");
        // R9 bitwise
        send(AND,  2'd0, 0, 0, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, 64'hF000_F000_0000_0F0F, "R9 and");
        send(ANDN, 2'd0, 0, 0, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, 64'h00F0_00F0_0000_F0F0, "R9 andn");
        send(OR,   2'd0, 0, 0, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, 64'hFFF0_FFF0_FFFF_FFFF, "R9 or");
        send(XOR,  2'd0, 0, 0, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, 64'h0FF0_0FF0_FFFF_F0F0, "R9 xor");
        // R10 pack
        send(PCK, 2'd1, 0, 1, 64'h0100_FF80_007F_FF00, 64'h0000_0001_FFFF_8000, 64'h0001_FF80_7F80_7F80, "R10 pack signed half");
        send(PCK, 2'd1, 0, 0, 64'h0100_FF80_007F_FF00, 64'h0000_0001_FFFF_8000, 64'h0001_0000_FF00_7F00, "R10 pack unsigned half");
        send(PCK, 2'd2, 0, 1, 64'h0001_0000_FFFF_8000, 64'h0000_0005_8000_0000, 64'h0005_8000_7FFF_8000, "R10 pack signed word");
        send(PCK, 2'd0, 0, 1, 64'h0100_FF80_007F_FF00, 64'h1, 64'h0, "R10 pack byte zero");
        // R11 unpack
        send(ULO, 2'd0, 0, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, 64'hB3A3_B2A2_B1A1_B0A0, "R11 unpklo byte");
        send(UHI, 2'd0, 0, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, 64'hB7A7_B6A6_B5A5_B4A4, "R11 unpkhi byte");
        send(ULO, 2'd1, 0, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, 64'hB3B2_A3A2_B1B0_A1A0, "R11 unpklo half");
        send(UHI, 2'd2, 0, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, 64'hB7B6_B5B4_A7A6_A5A4, "R11 unpkhi word");
        // R12 unassigned opcode
        send(5'd17, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R12 unused opcode");
        send(OR, 2'd0, 0, 0, 64'h1234_0000_0000_0000, 64'h0000_0000_0000_5678, 64'h1234_0000_0000_5678, "R1 last before idle");

        // R1: idle cycles give no valid and a held result
        idle(1);
        check("R1 idle valid low", {63'd0, out_valid}, 64'd0);
        check("R1 idle result held", result, 64'h1234_0000_0000_5678);
        check("R1 queue drained", 64'(exp_q.size()), 64'd0);

        // R1: reset clears an existing result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears result", result, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule